// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block moves a single data word from a writer clocked by `clk_a` to a reader clocked by `clk_b`. The word takes a direct path that does not pass through the bulk FIFO that sits beside it. The writer stores a word with a mailbox-qualified write on port A. The store pulls an active-low occupancy flag low, and the flag blocks any further mailbox writes. The reader takes the word with a mailbox-qualified read on port B. That read returns the flag high on the writer's side once the event has crossed back into `clk_a`.

Each event crosses the clock boundary as a level toggle through a two-flop synchronizer. The stored word never changes while the flag is low, so the reader can sample it directly. Port B also carries the output selection. When port B is driving, the mailbox select chooses between the stored word and the FIFO output register. When port B is deselected, the drive enable is low, which tells the pad logic to float the bus.

Top module: `xdom_mailbox`

## Requirements
- R1: A port A cycle with `a_sel_n`=0, `a_en`=1, `a_write`=1 and `a_mbx`=1, taken while `mbx_full_n`=1, stores `a_data` on that `clk_a` rising edge, and `mbx_full_n` reads 0 after that edge.
- R2: While `mbx_full_n`=0, a mailbox write on port A is ignored: the stored word and the flag stay as they were.
- R3: A port A write that lacks any one of `a_sel_n`=0, `a_en`=1 or `a_mbx`=1 leaves the stored word and the flag unchanged.
- R4: A port B cycle with `b_sel_n`=0, `b_en`=1, `b_read`=1 and `b_mbx`=1 consumes the word, provided it comes at least three `clk_b` edges after the write. `mbx_full_n` then returns to 1 within three `clk_a` rising edges after the consuming `clk_b` edge.
- R5: Reset (`rst_a` and `rst_b` high, synchronous) sets `mbx_full_n` to 1 and clears the stored word to zero.
- R6: `b_drive` is 1 exactly when `b_sel_n`=0 and `b_read`=1. Otherwise it is 0, and the port B pads float.
- R7: While `b_drive`=1, `b_q` carries the stored mailbox word when `b_mbx`=1 and `fifo_q` when `b_mbx`=0.
- R8: A port B read with `b_mbx`=0 does not consume the mailbox: `mbx_full_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Writer clock |
| rst_a | input | 1 | Synchronous active-high reset, `clk_a` domain |
| a_sel_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A transfer enable |
| a_write | input | 1 | Port A direction, 1 = write |
| a_mbx | input | 1 | Port A mailbox select |
| a_data | input | W | Word offered by the writer |
| mbx_full_n | output | 1 | Occupancy flag, 0 = mailbox holds an unread word |
| clk_b | input | 1 | Reader clock |
| rst_b | input | 1 | Synchronous active-high reset, `clk_b` domain |
| b_sel_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B transfer enable |
| b_read | input | 1 | Port B direction, 1 = read |
| b_mbx | input | 1 | Port B mailbox select |
| fifo_q | input | W | FIFO output register contents |
| b_q | output | W | Port B output data |
| b_drive | output | 1 | Port B pad drive enable |

## Verification
The checker tests the writer-side rules on every cycle. An accepted write drops the flag and captures the data. The stored word holds while the flag is low. Reset raises the flag. The port B selection and drive enable are also checked against the stored word and the FIFO input. Only the bench scenarios can show the cross-clock round trip: that a consuming read brings the flag back within three writer-clock edges, and that a non-mailbox read leaves it low. They also show that the scoreboard receives exactly the accepted words in order, and that a blocked write never overwrites the pending word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_W_DEF    = 36;
    localparam int SYNC_DEF     = 2;

    typedef struct packed {
        logic sel_n;
        logic en;
        logic dir;
        logic mbx;
    } port_ctl_t;

    function automatic logic mbx_hit(port_ctl_t c);
        return !c.sel_n && c.en && c.dir && c.mbx;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
    import mbx_pkg::*;
#(
    parameter int W      = MBX_W_DEF,
    parameter int STAGES = SYNC_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  port_ctl_t    ctl,
    input  logic [W-1:0] din,
    input  logic         rd_tog_async,
    output logic [W-1:0] word,
    output logic         wr_tog,
    output logic         full_n
);
    logic rd_tog_s;
    logic accept;

    mbx_sync #(.STAGES(STAGES)) u_rd_sync (
        .clk (clk),
        .rst (rst),
        .d   (rd_tog_async),
        .q   (rd_tog_s)
    );

    assign accept = mbx_hit(ctl) && full_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            word   <= '0;
            wr_tog <= 1'b0;
            full_n <= 1'b1;
        end else if (accept) begin
            word   <= din;
            wr_tog <= ~wr_tog;
            full_n <= 1'b0;
        end else begin
            full_n <= (rd_tog_s == wr_tog);
        end
    end
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
    import mbx_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  port_ctl_t ctl,
    input  logic      wr_tog_async,
    output logic      rd_tog
);
    logic wr_tog_s;
    logic pending;

    mbx_sync #(.STAGES(STAGES)) u_wr_sync (
        .clk (clk),
        .rst (rst),
        .d   (wr_tog_async),
        .q   (wr_tog_s)
    );

    assign pending = (wr_tog_s != rd_tog);

    always_ff @(posedge clk) begin
        if (rst)                           rd_tog <= 1'b0;
        else if (mbx_hit(ctl) && pending)  rd_tog <= ~rd_tog;
    end
endmodule

// File: rtl/mbx_out_mux.sv
module mbx_out_mux #(
    parameter int W = 36
) (
    input  logic         sel_n,
    input  logic         rd,
    input  logic         mbx,
    input  logic [W-1:0] mbx_word,
    input  logic [W-1:0] fifo_word,
    output logic [W-1:0] q,
    output logic         drive
);
    always_comb begin
        drive = !sel_n && rd;
        q     = mbx ? mbx_word : fifo_word;
    end
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
    import mbx_pkg::*;
#(
    parameter int W           = MBX_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic         clk_a,
    input  logic         rst_a,
    input  logic         a_sel_n,
    input  logic         a_en,
    input  logic         a_write,
    input  logic         a_mbx,
    input  logic [W-1:0] a_data,
    output logic         mbx_full_n,
    input  logic         clk_b,
    input  logic         rst_b,
    input  logic         b_sel_n,
    input  logic         b_en,
    input  logic         b_read,
    input  logic         b_mbx,
    input  logic [W-1:0] fifo_q,
    output logic [W-1:0] b_q,
    output logic         b_drive
);
    port_ctl_t    a_ctl, b_ctl;
    logic [W-1:0] mbx_word;
    logic         wr_tog, rd_tog;

    assign a_ctl = '{sel_n: a_sel_n, en: a_en, dir: a_write, mbx: a_mbx};
    assign b_ctl = '{sel_n: b_sel_n, en: b_en, dir: b_read,  mbx: b_mbx};

    mbx_wr_side #(.W(W), .STAGES(SYNC_STAGES)) u_wr (
        .clk          (clk_a),
        .rst          (rst_a),
        .ctl          (a_ctl),
        .din          (a_data),
        .rd_tog_async (rd_tog),
        .word         (mbx_word),
        .wr_tog       (wr_tog),
        .full_n       (mbx_full_n)
    );

    mbx_rd_side #(.STAGES(SYNC_STAGES)) u_rd (
        .clk          (clk_b),
        .rst          (rst_b),
        .ctl          (b_ctl),
        .wr_tog_async (wr_tog),
        .rd_tog       (rd_tog)
    );

    mbx_out_mux #(.W(W)) u_mux (
        .sel_n     (b_sel_n),
        .rd        (b_read),
        .mbx       (b_mbx),
        .mbx_word  (mbx_word),
        .fifo_word (fifo_q),
        .q         (b_q),
        .drive     (b_drive)
    );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         rst_a,
    input logic         a_sel_n,
    input logic         a_en,
    input logic         a_write,
    input logic         a_mbx,
    input logic [W-1:0] a_data,
    input logic         mbx_full_n,
    input logic         clk_b,
    input logic         rst_b,
    input logic         b_sel_n,
    input logic         b_read,
    input logic         b_mbx,
    input logic [W-1:0] fifo_q,
    input logic [W-1:0] b_q,
    input logic         b_drive,
    input logic [W-1:0] mbx_word
);
    logic a_try;
    assign a_try = !a_sel_n && a_en && a_write && a_mbx;

    // R1: accepted write drops the flag
    p_flag_drop_r1: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_try && mbx_full_n) |=> !mbx_full_n);

    // R1: accepted write captures the offered word
    p_capture_r1: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_try && mbx_full_n) |=> (mbx_word == $past(a_data)));

    // R2: word frozen while occupied
    p_hold_r2: assert property (@(posedge clk_a) disable iff (rst_a)
        !mbx_full_n |=> $stable(mbx_word));

    // R3: unqualified cycle never changes the word
    p_no_touch_r3: assert property (@(posedge clk_a) disable iff (rst_a)
        !a_try |=> $stable(mbx_word));

    // R5: reset raises the flag
    p_reset_flag_r5: assert property (@(posedge clk_a) disable iff (1'b0)
        rst_a |=> mbx_full_n);

    // R7: mailbox selected on a driving port
    p_mux_mbx_r7: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_drive && b_mbx) |-> (b_q == mbx_word));

    // R7: FIFO selected on a driving port
    p_mux_fifo_r7: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_drive && !b_mbx) |-> (b_q == fifo_q));

    // R6: deselected port never drives
    p_float_r6: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_sel_n || !b_read) |-> !b_drive);
endmodule

bind xdom_mailbox mbx_chk #(.W(W)) u_chk (.*);

// File: tb/xdom_mailbox_test.sv
module xdom_mailbox_test;
    localparam int W = 36;

    logic         clk_a = 0, clk_b = 0;
    logic         rst_a, rst_b;
    logic         a_sel_n, a_en, a_write, a_mbx;
    logic [W-1:0] a_data, fifo_q, b_q;
    logic         mbx_full_n, b_drive;
    logic         b_sel_n, b_en, b_read, b_mbx;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] exp_q[$];

    always #2 clk_a = ~clk_a;   // 250 MHz
    always #3.5 clk_b = ~clk_b;

    xdom_mailbox #(.W(W)) uut (.*);

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver: one port A cycle; pushes to scoreboard when the bench expects acceptance
    task automatic a_cycle(input logic sel_n, en, mbx, input logic [W-1:0] d,
                           input bit expect_store);
        @(negedge clk_a);
        a_sel_n = sel_n; a_en = en; a_write = 1; a_mbx = mbx; a_data = d;
        @(negedge clk_a);
        a_sel_n = 1; a_en = 0; a_write = 0; a_mbx = 0;
        if (expect_store) exp_q.push_back(d);
    endtask

    // Monitor: one port B read; mailbox reads pop the scoreboard
    task automatic b_cycle(input logic mbx, input string req);
        logic [W-1:0] e;
        @(negedge clk_b);
        b_sel_n = 0; b_en = 1; b_read = 1; b_mbx = mbx;
        #1;
        if (mbx) begin
            e = (exp_q.size() != 0) ? exp_q.pop_front() : '0;
            check(b_q === e && b_drive === 1'b1, req, b_q, e);
        end else begin
            check(b_q === fifo_q && b_drive === 1'b1, "R7 fifo path", b_q, fifo_q);
        end
        @(negedge clk_b);
        b_sel_n = 1; b_en = 0; b_read = 0; b_mbx = 0;
    endtask

    task automatic flag_chk(input logic exp, input string req);
        check(mbx_full_n === exp, req, {{(W-1){1'b0}}, mbx_full_n}, {{(W-1){1'b0}}, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk_a);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_a = 1; rst_b = 1;
        a_sel_n = 1; a_en = 0; a_write = 0; a_mbx = 0; a_data = '0;
        b_sel_n = 1; b_en = 0; b_read = 0; b_mbx = 0;
        fifo_q = 36'hF1F0_5A5A5;
        repeat (4) @(posedge clk_b);
        @(negedge clk_a); rst_a = 0;
        @(negedge clk_b); rst_b = 0;

        // R5 reset state, R6 deselected
        #1;
        flag_chk(1'b1, "R5 reset flag");
        check(b_drive === 1'b0, "R6 deselected", {{(W-1){1'b0}}, b_drive}, '0);
        b_sel_n = 0; b_read = 0; #1;
        check(b_drive === 1'b0, "R6 write direction", {{(W-1){1'b0}}, b_drive}, '0);
        b_sel_n = 1;

        // R3 unqualified writes: no flag change, word stays zero
        a_cycle(1, 1, 1, 36'h111111111, 0);
        a_cycle(0, 0, 1, 36'h222222222, 0);
        a_cycle(0, 1, 0, 36'h333333333, 0);
        #1; flag_chk(1'b1, "R3 flag untouched");
        exp_q.push_back('0);
        b_cycle(1, "R5 R3 word still zero");

        // R1 accepted write
        a_cycle(0, 1, 1, 36'hABCDE1234, 1);
        #1; flag_chk(1'b0, "R1 flag low");

        // R2 blocked write
        a_cycle(0, 1, 1, 36'h0DEADBEEF, 0);
        #1; flag_chk(1'b0, "R2 flag still low");

        // R8 non-mailbox read does not consume
        repeat (3) @(posedge clk_b);
        b_cycle(0, "R7");
        repeat (6) @(posedge clk_a);
        #1; flag_chk(1'b0, "R8 flag stays low");

        // R4 / R2 / R7 consuming read returns R1 word
        b_cycle(1, "R2 R7 stored word");
        // consumption edge was the clk_b posedge before the last negedge
        repeat (3) @(posedge clk_a);
        #1; flag_chk(1'b1, "R4 flag back within three edges");

        // second round, different pattern
        fifo_q = 36'h0_0000_FFFF;
        a_cycle(0, 1, 1, 36'h5_5555_AAAA, 1);
        #1; flag_chk(1'b0, "R1 second write");
        repeat (3) @(posedge clk_b);
        b_cycle(0, "R7");
        b_cycle(1, "R4 R7 second word");
        repeat (3) @(posedge clk_a);
        #1; flag_chk(1'b1, "R4 second release");

        // third write after release accepted
        a_cycle(0, 1, 1, 36'hF_0F0F_0F0F, 1);
        repeat (3) @(posedge clk_b);
        b_cycle(1, "R1 third word");
        repeat (3) @(posedge clk_a);
        #1; flag_chk(1'b1, "R4 third release");
        check(exp_q.size() == 0, "R1 scoreboard drained", W'(exp_q.size()), '0);

        finish_run();
    end
endmodule